// File: doc/BRIEF.md
# Three-wire serial control register slave

This block is the control-port slave of an audio receiver/converter. A host drives three wires into it: a serial clock, a mode line and a data line. The mode line sets the meaning of each transfer. When the line is low the bits form an address byte. When it is high they form a data transfer. Bits are shifted least significant bit first, and each is taken on a rising edge of the serial clock. The three wires are asynchronous to the system clock. They pass through a synchronizer, and edges are found in the system clock domain.

An address byte opens a write session, a read session or no session. In a data transfer the first byte is a register pointer. The 16-bit words that follow are written into a small register file, or they are shifted back out of the block. The register file drives the mute, de-emphasis, bass-boost and PLL-reset controls. A read-only status register returns the lock, PCM-valid, pre-emphasis and clock-accuracy inputs. After reset the output is muted, and it stays muted until the host clears the mute bit.

The frame decoder has seven states:
- `S_IGNORE` is the reset state. It drops data transfers.
- `S_ADDR` collects the address byte.
- `S_HOLD` waits for the mode line to rise.
- `S_PTR` collects the pointer byte.
- `S_WR` shifts in write words.
- `S_LOAD` latches a read word.
- `S_RD` shifts the read word out.

Its transitions are:
- A falling mode line goes from any state to `S_ADDR`, and it clears the session.
- The eighth address bit goes from `S_ADDR` to `S_HOLD`.
- A rising mode line goes from `S_HOLD` to `S_PTR` when a session is open. From every other case it goes to `S_IGNORE`.
- The eighth pointer bit goes from `S_PTR` to `S_LOAD` for a read session. For a write session it goes to `S_WR`, or to `S_IGNORE` when the pointer's flag bit is 1.
- `S_LOAD` always goes to `S_RD` after one cycle.
- The sixteenth bit goes from `S_RD` back to `S_LOAD`.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset, the outputs are as follows: `mute_o`=1, `bass_o`=0, `deemph_o`=0, `pll_rst_o`=0 and `sc_data_oe`=0. The control register reads 0x0003.
- R2: Serial bits are taken on rising edges of `sc_clk_i`, least significant bit first. While `sc_mode_i`=0, a byte whose bits [7:2] equal `DEV_ID` (default 6'b000110) and whose bits [1:0]=2'b10 opens a write session. With the default, this byte is 0x1A.
- R3: An address byte with bits [1:0]=2'b11 and a matching `DEV_ID` opens a read session (0x1B by default). Any other address byte makes the block ignore all data transfers until the next falling edge of the mode line. A read session never writes.
- R4: In a data transfer (`sc_mode_i`=1), the first byte is the pointer. Bit 0 is a flag and bits [7:1] are the register address. In a write session a flag of 1 causes the whole transfer to be ignored. In a read session the flag is not examined.
- R5: A write word changes the register file only after all 16 of its bits have been received. A partial word is dropped when the mode line falls.
- R6: The control register is at address 0x00: bit0 is mute, bit1 is mute-while-unlocked and bit2 is PLL reset. The tone register is at 0x01: bits[3:0] are bass boost and bits[5:4] are de-emphasis. Writes to any other address change nothing.
- R7: `mute_o` is 1 when the mute bit is set. It is also 1 when both the mute-while-unlocked bit is set and `pll_lock_i`=0. Otherwise it is 0.
- R8: The status register is at 0x10: bit0 is lock, bit1 is PCM-valid, bit2 is pre-emphasis and bits[4:3] are clock accuracy. The accuracy codes are 00=level II, 01=level I, 10=level III and 11=undefined. In a read session, `sc_data_oe`=1 and `sc_data_o` carries bit k of the word from the k-th rising edge after the pointer byte up to the next one.
- R9: Reading 0x00 or 0x01 returns the stored fields, and every undefined bit reads as 0.
- R10: Successive write words within one data transfer all go to the same pointed register, and the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_clk_i | input | 1 | Serial clock from host (idle high) |
| sc_mode_i | input | 1 | 0 = address transfer, 1 = data transfer |
| sc_data_i | input | 1 | Serial data from host |
| sc_data_o | output | 1 | Serial read data to host |
| sc_data_oe | output | 1 | Drive enable for `sc_data_o` |
| pll_lock_i | input | 1 | Clock recovery locked |
| pcm_valid_i | input | 1 | Valid PCM data detected |
| preemph_i | input | 1 | Pre-emphasis flagged in the input stream |
| clk_acc_i | input | 2 | Clock-accuracy level code |
| mute_o | output | 1 | Output mute |
| deemph_o | output | 2 | De-emphasis selection |
| bass_o | output | 4 | Bass-boost setting |
| pll_rst_o | output | 1 | Hold clock recovery in reset |

## Verification
The assertions assume the following of the host:
- It holds the mode and data lines steady across every rising edge of the serial clock.
- It keeps each serial-clock level for several system cycles, so that every edge is seen once after synchronization.
- It changes the mode line only while the serial clock is high.

The bench drives every wire from a single task. Each task holds each level for six system cycles, and it changes the mode line only between bytes, with the clock high. It therefore never produces a skewed or too-narrow serial edge.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W = 7;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IGNORE,
        S_ADDR,
        S_HOLD,
        S_PTR,
        S_WR,
        S_LOAD,
        S_RD
    } fsm_state_t;

    typedef enum logic [1:0] {
        SESS_NONE,
        SESS_WR,
        SESS_RD
    } session_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
    import tw_pkg::*;
#(
    parameter logic [5:0] DEV_ID = 6'b000110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mode_s,
    input  logic              data_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST_BIT_BYTE = CW'(BYTE_W - 1);
    localparam logic [CW-1:0] LAST_BIT_WORD = CW'(WORD_W - 1);

    fsm_state_t        state_q, state_n;
    session_t          sess_q, sess_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [WORD_W-1:0] sh_q, sh_n, rdw_q, rdw_n;
    logic [ADDR_W-1:0] ptr_q, ptr_n;
    logic              sclk_q, mode_q;
    logic              bit_ev, m_fall, m_rise;
    logic [WORD_W-1:0] sh_in;
    logic [BYTE_W-1:0] byte_in;

    assign bit_ev  = sclk_s & ~sclk_q;
    assign m_fall  = mode_q & ~mode_s;
    assign m_rise  = ~mode_q & mode_s;
    assign sh_in   = {data_s, sh_q[WORD_W-1:1]};
    assign byte_in = sh_in[WORD_W-1 -: BYTE_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IGNORE;
            sess_q  <= SESS_NONE;
            cnt_q   <= '0;
            sh_q    <= '0;
            rdw_q   <= '0;
            ptr_q   <= '0;
            sclk_q  <= 1'b1;
            mode_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            sess_q  <= sess_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            rdw_q   <= rdw_n;
            ptr_q   <= ptr_n;
            sclk_q  <= sclk_s;
            mode_q  <= mode_s;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        sess_n  = sess_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        rdw_n   = rdw_q;
        ptr_n   = ptr_q;
        if (m_fall) begin
            state_n = S_ADDR;
            sess_n  = SESS_NONE;
            cnt_n   = '0;
        end else if (m_rise) begin
            cnt_n = '0;
            if (state_q == S_HOLD && sess_q != SESS_NONE) begin
                state_n = S_PTR;
            end else begin
                state_n = S_IGNORE;
                sess_n  = SESS_NONE;
            end
        end else begin
            unique case (state_q)
                S_IGNORE, S_HOLD: ;
                S_ADDR: if (bit_ev) begin
                    sh_n  = sh_in;
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT_BYTE) begin
                        cnt_n   = '0;
                        state_n = S_HOLD;
                        if (byte_in[7:2] != DEV_ID)      sess_n = SESS_NONE;
                        else if (byte_in[1:0] == 2'b10)  sess_n = SESS_WR;
                        else if (byte_in[1:0] == 2'b11)  sess_n = SESS_RD;
                        else                             sess_n = SESS_NONE;
                    end
                end
                S_PTR: if (bit_ev) begin
                    sh_n  = sh_in;
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT_BYTE) begin
                        cnt_n = '0;
                        ptr_n = byte_in[7:1];
                        if (sess_q == SESS_RD) state_n = S_LOAD;
                        else if (byte_in[0])   state_n = S_IGNORE;
                        else                   state_n = S_WR;
                    end
                end
                S_WR: if (bit_ev) begin
                    sh_n  = sh_in;
                    cnt_n = cnt_q + 1'b1;
                end
                S_LOAD: begin
                    rdw_n   = rd_data;
                    cnt_n   = '0;
                    state_n = S_RD;
                end
                S_RD: if (bit_ev) begin
                    rdw_n = rdw_q >> 1;
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT_WORD) state_n = S_LOAD;
                end
                default: state_n = S_IGNORE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state_q == S_WR) && bit_ev && !m_fall && !m_rise &&
                  (cnt_q == LAST_BIT_WORD);
        wr_data = sh_in;
        wr_addr = ptr_q;
        rd_addr = ptr_q;
        sdo     = (state_q == S_RD) ? rdw_q[0] : 1'b0;
        sdo_oe  = (state_q == S_RD);
    end

    // R3: only a read session may drive the line
    a_r3_oe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> sess_q == SESS_RD);
    // R2: commits happen only inside a write session
    a_r2_write_needs_session: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sess_q == SESS_WR);
    // R2: address collection only while the mode line is low
    a_r2_addr_in_addr_mode: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_ADDR |-> !mode_q);
    // R5: a falling mode line never leaves a commit pending
    a_r5_no_commit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        m_fall |=> !wr_en);
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
    import tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h00,
    parameter logic [ADDR_W-1:0] TONE_ADDR = 7'h01,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pll_lock_i,
    input  logic              pcm_valid_i,
    input  logic              preemph_i,
    input  logic [1:0]        clk_acc_i,
    output logic              mute_q,
    output logic              mute_unlk_q,
    output logic              pll_rst_q,
    output logic [3:0]        bass_q,
    output logic [1:0]        deemph_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_q      <= 1'b1;
            mute_unlk_q <= 1'b1;
            pll_rst_q   <= 1'b0;
            bass_q      <= '0;
            deemph_q    <= '0;
        end else if (wr_en) begin
            if (wr_addr == CTRL_ADDR) begin
                mute_q      <= wr_data[0];
                mute_unlk_q <= wr_data[1];
                pll_rst_q   <= wr_data[2];
            end else if (wr_addr == TONE_ADDR) begin
                bass_q   <= wr_data[3:0];
                deemph_q <= wr_data[5:4];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR)      rd_data[2:0] = {pll_rst_q, mute_unlk_q, mute_q};
        else if (rd_addr == TONE_ADDR) rd_data[5:0] = {deemph_q, bass_q};
        else if (rd_addr == STAT_ADDR) rd_data[4:0] = {clk_acc_i, preemph_i, pcm_valid_i, pll_lock_i};
    end

    // R6: settings move only on a commit strobe
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({mute_q, mute_unlk_q, pll_rst_q, bass_q, deemph_q}));
    // R1: the start-up mute is released only by a host write
    a_r1_mute_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute_q) |-> $past(wr_en));
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
    import tw_pkg::*;
#(
    parameter logic [5:0]        DEV_ID      = 6'b000110,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 7'h00,
    parameter logic [ADDR_W-1:0] TONE_ADDR   = 7'h01,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 7'h10,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sc_clk_i,
    input  logic       sc_mode_i,
    input  logic       sc_data_i,
    output logic       sc_data_o,
    output logic       sc_data_oe,
    input  logic       pll_lock_i,
    input  logic       pcm_valid_i,
    input  logic       preemph_i,
    input  logic [1:0] clk_acc_i,
    output logic       mute_o,
    output logic [1:0] deemph_o,
    output logic [3:0] bass_o,
    output logic       pll_rst_o
);
    logic [2:0]        pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [WORD_W-1:0] wr_data, rd_data;
    logic              mute_q, mute_unlk_q;

    tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sc_clk_i, sc_mode_i, sc_data_i}),
        .q_o   (pins_s)
    );

    tw_frame_fsm #(.DEV_ID(DEV_ID)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[2]),
        .mode_s  (pins_s[1]),
        .data_s  (pins_s[0]),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sdo     (sc_data_o),
        .sdo_oe  (sc_data_oe)
    );

    tw_regfile #(.CTRL_ADDR(CTRL_ADDR), .TONE_ADDR(TONE_ADDR), .STAT_ADDR(STAT_ADDR)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .pll_lock_i  (pll_lock_i),
        .pcm_valid_i (pcm_valid_i),
        .preemph_i   (preemph_i),
        .clk_acc_i   (clk_acc_i),
        .mute_q      (mute_q),
        .mute_unlk_q (mute_unlk_q),
        .pll_rst_q   (pll_rst_o),
        .bass_q      (bass_o),
        .deemph_q    (deemph_o)
    );

    // R7: unlock muting gated by its enable bit
    assign mute_o = mute_q | (mute_unlk_q & ~pll_lock_i);
endmodule

// File: tb/sim_tw_ctrl_slave.sv
module sim_tw_ctrl_slave;
    localparam int HALF = 6;
    localparam logic [7:0] A_WR = 8'h1A;
    localparam logic [7:0] A_RD = 8'h1B;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sc_clk = 1'b1, sc_mode = 1'b1, sc_din = 1'b0;
    logic sc_dout, sc_oe;
    logic lock = 1'b1, pcmv = 1'b0, pre = 1'b0;
    logic [1:0] acc = 2'b00;
    logic mute, pllr;
    logic [1:0] deemph;
    logic [3:0] bass;
    int checks = 0, errors = 0;
    logic oe_seen;

    always #4 clk = ~clk;

    tw_ctrl_slave u0 (
        .clk(clk), .rst_n(rst_n), .sc_clk_i(sc_clk), .sc_mode_i(sc_mode),
        .sc_data_i(sc_din), .sc_data_o(sc_dout), .sc_data_oe(sc_oe),
        .pll_lock_i(lock), .pcm_valid_i(pcmv), .preemph_i(pre), .clk_acc_i(acc),
        .mute_o(mute), .deemph_o(deemph), .bass_o(bass), .pll_rst_o(pllr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        sc_mode = m;
        wait_cyc(HALF);
    endtask

    task automatic send_bit(input logic b);
        sc_din = b;
        sc_clk = 1'b0;
        wait_cyc(HALF);
        sc_clk = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic wr_words(input logic [7:0] ab, input logic [7:0] pb,
                            input logic [15:0] w0, input int nw, input logic [15:0] w1);
        set_mode(1'b0);
        send_bits({8'h00, ab}, 8);
        set_mode(1'b1);
        send_bits({8'h00, pb}, 8);
        send_bits(w0, 16);
        if (nw > 1) send_bits(w1, 16);
        wait_cyc(HALF);
    endtask

    task automatic rd_word(input logic [6:0] ra, output logic [15:0] w);
        set_mode(1'b0);
        send_bits({8'h00, A_RD}, 8);
        set_mode(1'b1);
        send_bits({8'h00, ra, 1'b1}, 8);
        oe_seen = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sc_clk = 1'b0;
            wait_cyc(HALF);
            w[i] = sc_dout;
            oe_seen = oe_seen & sc_oe;
            sc_clk = 1'b1;
            wait_cyc(HALF);
        end
        set_mode(1'b0);
        wait_cyc(HALF);
    endtask

    initial begin : watchdog
        wait_cyc(195000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] w;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        // R1 reset state
        chk("R1 mute", 16'(mute), 16'h1);
        chk("R1 bass", 16'(bass), 16'h0);
        chk("R1 deemph", 16'(deemph), 16'h0);
        chk("R1 pll_rst", 16'(pllr), 16'h0);
        chk("R1 oe", 16'(sc_oe), 16'h0);
        rd_word(7'h00, w);
        chk("R1 R9 ctrl readback", w, 16'h0003);
        chk("R8 oe during read", 16'(oe_seen), 16'h1);
        chk("R8 oe after read", 16'(sc_oe), 16'h0);

        // R5 partial word dropped
        set_mode(1'b0);
        send_bits({8'h00, A_WR}, 8);
        set_mode(1'b1);
        send_bits(16'h0000, 8);
        send_bits(16'h0000, 10);
        set_mode(1'b0);
        wait_cyc(HALF);
        chk("R5 partial dropped", 16'(mute), 16'h1);

        // R3 device-id sweep, write op
        for (int d = 0; d < 64; d++) begin
            if (d != 6) begin
                wr_words({6'(d), 2'b10}, 8'h00, 16'h0000, 1, 16'h0);
                chk("R3 wrong device", 16'(mute), 16'h1);
            end
        end
        // R2 R3 op sweep with matching device
        for (int op = 0; op < 4; op++) begin
            if (op != 2) begin
                wr_words({6'b000110, 2'(op)}, 8'h00, 16'h0000, 1, 16'h0);
                chk("R3 non-write op", 16'(mute), 16'h1);
            end
        end
        // R4 flag bit set in write session
        wr_words(A_WR, 8'h01, 16'h0000, 1, 16'h0);
        chk("R4 flag ignored", 16'(mute), 16'h1);
        // R6 unmapped address
        wr_words(A_WR, {7'h05, 1'b0}, 16'h0000, 1, 16'h0);
        rd_word(7'h00, w);
        chk("R6 unmapped write", w, 16'h0003);

        // R2 R7 valid writes and unlock mute
        wr_words(A_WR, 8'h00, 16'hFFFA, 1, 16'h0);
        chk("R2 mute cleared", 16'(mute), 16'h0);
        lock = 1'b0;
        wait_cyc(2);
        chk("R7 unlock mutes", 16'(mute), 16'h1);
        wr_words(A_WR, 8'h00, 16'h0000, 1, 16'h0);
        chk("R7 unlock mute disabled", 16'(mute), 16'h0);
        wr_words(A_WR, 8'h00, 16'h0004, 1, 16'h0);
        chk("R6 pll reset", 16'(pllr), 16'h1);
        rd_word(7'h00, w);
        chk("R9 ctrl bits", w, 16'h0004);
        lock = 1'b1;

        // R10 two words, last wins
        wr_words(A_WR, 8'h02, 16'h0015, 2, 16'h002A);
        chk("R10 bass", 16'(bass), 16'hA);
        chk("R10 deemph", 16'(deemph), 16'h2);

        // R6 R9 tone sweep
        for (int v = 0; v < 64; v++) begin
            wr_words(A_WR, 8'h02, 16'hFFC0 | 16'(v), 1, 16'h0);
            chk("R6 bass", 16'(bass), 16'(v % 16));
            chk("R6 deemph", 16'(deemph), 16'(v / 16));
            if (v % 8 == 3) begin
                rd_word(7'h01, w);
                chk("R9 tone readback", w, 16'(v));
            end
        end

        // R8 status sweep
        for (int s = 0; s < 32; s++) begin
            lock = s[0]; pcmv = s[1]; pre = s[2]; acc = 2'(s / 8);
            rd_word(7'h10, w);
            chk("R8 status", w, 16'(s));
            chk("R8 oe", 16'(oe_seen), 16'h1);
        end
        lock = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule